// File: doc/BRIEF.md
# Base-Delta Compressed Translation Buffer

This block caches virtual-to-physical page translations for a throughput core. Nearby pages share their upper address bits, so the block keeps those upper bits once, in a small set of base register pairs (a VPN base and a PFN base each). A compressed entry points at one base pair and holds several slots. Each slot carries only the low-order difference of its VPN and of its PFN. Translations that cannot use any base pair go to a small uncompressed partition that stores full page numbers.

A lookup presents a VPN and receives hit and PFN one cycle later. A fill delivers a VPN/PFN pair from the next level down and is absorbed in the cycle it arrives. Fills and lookups proceed together, so a fill never holds back a lookup. A flush empties the whole structure in one cycle.

With default parameters both page numbers are 20 bits wide. The upper 12 bits form the base and the lower 8 bits form the delta. There are 4 base pairs, 8 compressed entries of 4 slots each, and 8 uncompressed entries.

Top module: `delta_tlb`

## Requirements
- R1: `lk_hit` and `lk_pfn` are registered. They reflect a request presented one cycle earlier. A cycle with `lk_valid` low, or a miss, yields `lk_hit`=0 and `lk_pfn`=0. Both outputs are 0 after reset.
- R2: A fill is stored compressed when its VPN bits [19:8] and PFN bits [19:8] both equal an in-use base pair, or when a base pair is free. A later hit returns PFN = {PFN base, stored 8-bit delta}.
- R3: Up to 4 translations that share one base pair occupy a single compressed entry. A fill first takes a free slot in an entry of its base pair, so 32 translations of one base pair all stay resident.
- R4: At most 4 base pairs exist. A fill whose upper bits match no in-use pair while all 4 pairs are in use is written, full width, to the uncompressed partition and hits from there.
- R5: The uncompressed partition takes its lowest free entry first. When all 8 entries are full, it replaces entries in round-robin order starting at entry 0.
- R6: When a compressed fill finds no free slot for its base pair, it claims a new entry in round-robin order (0,1,...,7,0,...). This clears all four slots of the victim.
- R7: A base pair becomes free as soon as no valid compressed entry refers to it, and a later fill with new upper bits can then claim it.
- R8: A flush clears every valid bit, every base register and both replacement pointers in one cycle. A fill in the same cycle as a flush is discarded, and lookups in the next cycle miss.
- R9: A lookup in the same cycle as the fill of that VPN, with the VPN not yet present, returns a miss. The same lookup one cycle later hits.
- R10: A fill whose VPN is already present in either partition is dropped. The earlier PFN stays, and no second copy of the VPN exists.
- R11: A fill in progress does not disturb a lookup of another resident VPN in the same cycle; that lookup hits with its result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Registered hit for the previous cycle's request |
| lk_pfn | output | 20 | Registered physical frame number, 0 on a miss |
| fill_valid | input | 1 | Fill strobe from the lower level |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_pfn | input | 20 | Physical frame number being filled |
| flush | input | 1 | Empties all partitions and base registers |

## Verification
A lookup result is due exactly one rising edge after the request, and a fill or flush becomes visible to lookups presented in the cycle after it. The bench drives every input on the falling edge. It reads `lk_hit` and `lk_pfn` on the next falling edge, which lies just after the single capturing edge. Same-cycle cases (R9, R11) present fill and lookup on one falling edge, check the miss or hit one half-period after the edge, and then repeat the lookup to confirm the fill landed. Replacement cases count the fills from a flush, so the round-robin victims are known before sampling.

// File: rtl/delta_tlb_pkg.sv
package delta_tlb_pkg;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_PFN_W   = 20;
  localparam int unsigned DEF_DELTA_W = 8;
  localparam int unsigned DEF_NBASE   = 4;
  localparam int unsigned DEF_CENT    = 8;
  localparam int unsigned DEF_SLOTS   = 4;
  localparam int unsigned DEF_UENT    = 8;

  // fill routing decision
  typedef enum logic [2:0] {
    FP_IDLE,
    FP_SLOT,
    FP_ENT_OLDBASE,
    FP_ENT_NEWBASE,
    FP_UNCOMP
  } fill_path_e;
endpackage

// File: rtl/delta_tlb_bases.sv
module delta_tlb_bases #(
  parameter int unsigned NBASE = 4,
  parameter int unsigned VB_W  = 12,
  parameter int unsigned PB_W  = 12,
  localparam int unsigned BIDX_W = $clog2(NBASE)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [NBASE-1:0]            base_used,
  input  logic [VB_W-1:0]             q_vhi,
  input  logic [PB_W-1:0]             q_phi,
  input  logic                        wr_en,
  input  logic [BIDX_W-1:0]           wr_idx,
  output logic [NBASE-1:0][VB_W-1:0]  vbase,
  output logic [NBASE-1:0][PB_W-1:0]  pbase,
  output logic                        match_any,
  output logic [BIDX_W-1:0]           match_idx,
  output logic                        free_any,
  output logic [BIDX_W-1:0]           free_idx
);
  function automatic logic pair_eq(input logic used,
                                   input logic [VB_W-1:0] vb, input logic [PB_W-1:0] pb,
                                   input logic [VB_W-1:0] qv, input logic [PB_W-1:0] qp);
    return used && (vb == qv) && (pb == qp);
  endfunction

  always_comb begin
    match_any = 1'b0;
    match_idx = '0;
    free_any  = 1'b0;
    free_idx  = '0;
    for (int b = 0; b < NBASE; b++) begin
      if (!match_any && pair_eq(base_used[b], vbase[b], pbase[b], q_vhi, q_phi)) begin
        match_any = 1'b1;
        match_idx = BIDX_W'(b);
      end
      if (!free_any && !base_used[b]) begin
        free_any = 1'b1;
        free_idx = BIDX_W'(b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vbase <= '0;
      pbase <= '0;
    end else if (wr_en) begin
      vbase[wr_idx] <= q_vhi;
      pbase[wr_idx] <= q_phi;
    end
  end

  // only an unreferenced pair may be claimed
  p_claim_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !base_used[wr_idx]);
  // flush wipes every base register
  p_base_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vbase == '0) && (pbase == '0));
endmodule

// File: rtl/delta_tlb_cpart.sv
module delta_tlb_cpart #(
  parameter int unsigned NENT    = 8,
  parameter int unsigned NSLOT   = 4,
  parameter int unsigned NBASE   = 4,
  parameter int unsigned VB_W    = 12,
  parameter int unsigned PB_W    = 12,
  parameter int unsigned DELTA_W = 8,
  localparam int unsigned BIDX_W = $clog2(NBASE),
  localparam int unsigned EIDX_W = $clog2(NENT),
  localparam int unsigned SIDX_W = $clog2(NSLOT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [NBASE-1:0][VB_W-1:0]  vbase,
  input  logic [NBASE-1:0][PB_W-1:0]  pbase,
  input  logic [VB_W-1:0]             lk_hi,
  input  logic [DELTA_W-1:0]          lk_lo,
  input  logic [VB_W-1:0]             fl_hi,
  input  logic [DELTA_W-1:0]          fl_lo,
  input  logic [DELTA_W-1:0]          fl_plo,
  input  logic [BIDX_W-1:0]           sel_base,
  input  logic                        slot_wr,
  input  logic                        ent_alloc,
  output logic                        lk_hit,
  output logic [PB_W+DELTA_W-1:0]     lk_pfn,
  output logic                        fl_dup,
  output logic                        slot_free,
  output logic [NBASE-1:0]            base_used
);
  logic [NSLOT-1:0]   ent_v  [NENT];
  logic [BIDX_W-1:0]  ent_b  [NENT];
  logic [DELTA_W-1:0] ent_vd [NENT][NSLOT];
  logic [DELTA_W-1:0] ent_pd [NENT][NSLOT];
  logic [EIDX_W-1:0]  rr;
  logic [EIDX_W-1:0]  wr_ent;
  logic [SIDX_W-1:0]  wr_slot;

  function automatic logic slot_match(input logic v, input logic [VB_W-1:0] b,
                                      input logic [DELTA_W-1:0] d,
                                      input logic [VB_W-1:0] qh, input logic [DELTA_W-1:0] ql);
    return v && (b == qh) && (d == ql);
  endfunction

  function automatic logic [PB_W+DELTA_W-1:0] rebuild(input logic [PB_W-1:0] pb,
                                                      input logic [DELTA_W-1:0] pd);
    return {pb, pd};
  endfunction

  always_comb begin
    lk_hit    = 1'b0;
    lk_pfn    = '0;
    fl_dup    = 1'b0;
    slot_free = 1'b0;
    wr_ent    = '0;
    wr_slot   = '0;
    base_used = '0;
    for (int e = 0; e < NENT; e++) begin
      base_used[ent_b[e]] = base_used[ent_b[e]] | (|ent_v[e]);
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_match(ent_v[e][s], vbase[ent_b[e]], ent_vd[e][s], lk_hi, lk_lo)) begin
          lk_hit = 1'b1;
          lk_pfn = rebuild(pbase[ent_b[e]], ent_pd[e][s]);
        end
        if (slot_match(ent_v[e][s], vbase[ent_b[e]], ent_vd[e][s], fl_hi, fl_lo))
          fl_dup = 1'b1;
        if (!slot_free && (|ent_v[e]) && (ent_b[e] == sel_base) && !ent_v[e][s]) begin
          slot_free = 1'b1;
          wr_ent    = EIDX_W'(e);
          wr_slot   = SIDX_W'(s);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int e = 0; e < NENT; e++) begin
        ent_v[e] <= '0;
        ent_b[e] <= '0;
      end
      rr <= '0;
    end else if (slot_wr) begin
      ent_v[wr_ent][wr_slot]  <= 1'b1;
      ent_vd[wr_ent][wr_slot] <= fl_lo;
      ent_pd[wr_ent][wr_slot] <= fl_plo;
    end else if (ent_alloc) begin
      ent_v[rr]     <= NSLOT'(1);
      ent_b[rr]     <= sel_base;
      ent_vd[rr][0] <= fl_lo;
      ent_pd[rr][0] <= fl_plo;
      rr            <= (rr == EIDX_W'(NENT - 1)) ? '0 : rr + 1'b1;
    end
  end

  // at most one kind of compressed write per cycle
  p_one_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_wr && ent_alloc));
  // slot writes only into an open slot of the chosen pair
  p_slot_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr |-> slot_free);
  // every allocation moves the victim pointer
  p_victim_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_alloc |=> rr != $past(rr));
endmodule

// File: rtl/delta_tlb_upart.sv
module delta_tlb_upart #(
  parameter int unsigned NENT  = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20,
  localparam int unsigned IDX_W = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PFN_W-1:0] fl_pfn,
  input  logic             wr_en,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             fl_dup
);
  logic [NENT-1:0]  u_v;
  logic [VPN_W-1:0] u_vpn [NENT];
  logic [PFN_W-1:0] u_pfn [NENT];
  logic [IDX_W-1:0] ptr;
  logic             has_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] tgt;

  always_comb begin
    lk_hit   = 1'b0;
    lk_pfn   = '0;
    fl_dup   = 1'b0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NENT; i++) begin
      if (u_v[i] && u_vpn[i] == lk_vpn) begin
        lk_hit = 1'b1;
        lk_pfn = u_pfn[i];
      end
      if (u_v[i] && u_vpn[i] == fl_vpn) fl_dup = 1'b1;
      if (!has_free && !u_v[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    tgt = has_free ? free_idx : ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      u_v <= '0;
      ptr <= '0;
    end else if (wr_en) begin
      u_v[tgt]   <= 1'b1;
      u_vpn[tgt] <= fl_vpn;
      u_pfn[tgt] <= fl_pfn;
      if (!has_free) ptr <= (ptr == IDX_W'(NENT - 1)) ? '0 : ptr + 1'b1;
    end
  end

  // a present VPN is never written a second time
  p_uncomp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !fl_dup);
endmodule

// File: rtl/delta_tlb.sv
module delta_tlb
  import delta_tlb_pkg::*;
#(
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned PFN_W   = DEF_PFN_W,
  parameter int unsigned DELTA_W = DEF_DELTA_W,
  parameter int unsigned NBASE   = DEF_NBASE,
  parameter int unsigned CENT    = DEF_CENT,
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned UENT    = DEF_UENT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             flush
);
  localparam int unsigned VB_W   = VPN_W - DELTA_W;
  localparam int unsigned PB_W   = PFN_W - DELTA_W;
  localparam int unsigned BIDX_W = $clog2(NBASE);

  function automatic logic [VB_W-1:0] vhi(input logic [VPN_W-1:0] v);
    return v[VPN_W-1 -: VB_W];
  endfunction
  function automatic logic [PB_W-1:0] phi(input logic [PFN_W-1:0] p);
    return p[PFN_W-1 -: PB_W];
  endfunction
  function automatic logic [DELTA_W-1:0] lo_v(input logic [VPN_W-1:0] v);
    return v[DELTA_W-1:0];
  endfunction
  function automatic logic [DELTA_W-1:0] lo_p(input logic [PFN_W-1:0] p);
    return p[DELTA_W-1:0];
  endfunction

  logic [NBASE-1:0][VB_W-1:0] vbase;
  logic [NBASE-1:0][PB_W-1:0] pbase;
  logic [NBASE-1:0]           base_used;
  logic                       match_any, free_any;
  logic [BIDX_W-1:0]          match_idx, free_idx, sel_base;
  logic                       c_hit, u_hit, c_dup, u_dup, slot_free;
  logic [PFN_W-1:0]           c_pfn, u_pfn;
  logic                       fill_dup;
  fill_path_e                 path;

  assign fill_dup = c_dup | u_dup;
  assign sel_base = match_any ? match_idx : free_idx;

  always_comb begin
    path = FP_IDLE;
    if (fill_valid && !flush && !fill_dup) begin
      if (match_any)     path = slot_free ? FP_SLOT : FP_ENT_OLDBASE;
      else if (free_any) path = FP_ENT_NEWBASE;
      else               path = FP_UNCOMP;
    end
  end

  delta_tlb_bases #(.NBASE(NBASE), .VB_W(VB_W), .PB_W(PB_W)) u_bases (
    .clk(clk), .rst_n(rst_n), .flush(flush), .base_used(base_used),
    .q_vhi(vhi(fill_vpn)), .q_phi(phi(fill_pfn)),
    .wr_en(path == FP_ENT_NEWBASE), .wr_idx(free_idx),
    .vbase(vbase), .pbase(pbase), .match_any(match_any), .match_idx(match_idx),
    .free_any(free_any), .free_idx(free_idx)
  );

  delta_tlb_cpart #(.NENT(CENT), .NSLOT(SLOTS), .NBASE(NBASE), .VB_W(VB_W),
                    .PB_W(PB_W), .DELTA_W(DELTA_W)) u_cpart (
    .clk(clk), .rst_n(rst_n), .flush(flush), .vbase(vbase), .pbase(pbase),
    .lk_hi(vhi(lk_vpn)), .lk_lo(lo_v(lk_vpn)),
    .fl_hi(vhi(fill_vpn)), .fl_lo(lo_v(fill_vpn)), .fl_plo(lo_p(fill_pfn)),
    .sel_base(sel_base), .slot_wr(path == FP_SLOT),
    .ent_alloc((path == FP_ENT_OLDBASE) || (path == FP_ENT_NEWBASE)),
    .lk_hit(c_hit), .lk_pfn(c_pfn), .fl_dup(c_dup), .slot_free(slot_free),
    .base_used(base_used)
  );

  delta_tlb_upart #(.NENT(UENT), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_upart (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(lk_vpn),
    .fl_vpn(fill_vpn), .fl_pfn(fill_pfn), .wr_en(path == FP_UNCOMP),
    .lk_hit(u_hit), .lk_pfn(u_pfn), .fl_dup(u_dup)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit <= 1'b0;
      lk_pfn <= '0;
    end else begin
      lk_hit <= lk_valid && (c_hit || u_hit);
      lk_pfn <= !lk_valid ? '0 : c_hit ? c_pfn : u_hit ? u_pfn : '0;
    end
  end

  // a VPN lives in at most one partition
  p_single_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c_hit, u_hit}));
  // no request, no hit
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit && (lk_pfn == '0));
  // nothing survives a flush
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !c_hit && !u_hit);
  // fill of an absent VPN is invisible to a lookup in the same cycle
  p_same_cycle_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && lk_valid && (fill_vpn == lk_vpn) && !fill_dup) |=> !lk_hit);
endmodule

// File: tb/delta_tlb_test.sv
`timescale 1ns/1ps
module delta_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        flush = 1'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  delta_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .flush(flush)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [19:0] v, input bit eh, input logic [19:0] ep, input string req);
    lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk);
    chk(lk_hit == eh, {req, " hit"}, 32'(lk_hit), 32'(eh));
    chk(lk_pfn == (eh ? ep : 20'h0), {req, " pfn"}, 32'(lk_pfn), 32'(eh ? ep : 20'h0));
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p);
    fill_valid = 1'b1; fill_vpn = v; fill_pfn = p;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // R1: reset state and idle behaviour
  task automatic t_reset();
    chk(lk_hit == 1'b0, "R1 reset hit", 32'(lk_hit), 0);
    chk(lk_pfn == 20'h0, "R1 reset pfn", 32'(lk_pfn), 0);
  endtask

  // R2 / R1: compressed store, rebuild, idle cycle, absent VPN
  task automatic t_basic();
    do_flush();
    fill(20'h12345, 20'hABC67);
    look(20'h12345, 1'b1, 20'hABC67, "R2 rebuild");
    lk_valid = 1'b0; lk_vpn = 20'h12345;
    @(negedge clk);
    chk(lk_hit == 1'b0, "R1 idle no hit", 32'(lk_hit), 0);
    look(20'h12346, 1'b0, 20'h0, "R1 absent miss");
    fill(20'h12399, 20'hABC01);
    look(20'h12399, 1'b1, 20'hABC01, "R2 shared base");
  endtask

  // R3 packing capacity, R6 round-robin victim
  task automatic t_pack();
    do_flush();
    for (int i = 0; i < 32; i++) fill({12'h555, 8'(i)}, {12'h777, 8'(i * 3)});
    for (int i = 0; i < 32; i++) look({12'h555, 8'(i)}, 1'b1, {12'h777, 8'(i * 3)}, "R3 packed");
    fill({12'h555, 8'd40}, {12'h777, 8'd200});
    look({12'h555, 8'd40}, 1'b1, {12'h777, 8'd200}, "R6 new entry");
    for (int i = 0; i < 4; i++) look({12'h555, 8'(i)}, 1'b0, 20'h0, "R6 victim cleared");
    look({12'h555, 8'd4}, 1'b1, {12'h777, 8'd12}, "R6 next entry kept");
  endtask

  // R4: five bases, one of them only in the uncompressed partition
  task automatic t_base_limit();
    do_flush();
    for (int b = 0; b < 4; b++) fill({12'(12'h100 + b), 8'h10}, {12'(12'h200 + b), 8'h20});
    fill(20'h10020, 20'h30030);
    look(20'h10020, 1'b1, 20'h30030, "R4 spill to uncompressed");
    for (int b = 0; b < 4; b++) look({12'(12'h100 + b), 8'h10}, 1'b1, {12'(12'h200 + b), 8'h20}, "R4 bases kept");
  endtask

  // R5: uncompressed free-first then round robin
  task automatic t_uncomp();
    do_flush();
    for (int b = 0; b < 4; b++) fill({12'(12'h100 + b), 8'h10}, {12'(12'h200 + b), 8'h20});
    for (int k = 0; k < 9; k++) fill({12'(12'h400 + k), 8'h01}, {12'(12'h500 + k), 8'h02});
    look({12'h400, 8'h01}, 1'b0, 20'h0, "R5 oldest replaced");
    look({12'h401, 8'h01}, 1'b1, {12'h501, 8'h02}, "R5 second kept");
    look({12'h408, 8'h01}, 1'b1, {12'h508, 8'h02}, "R5 newest present");
  endtask

  // R7: base release after last referencing entry is evicted
  task automatic t_release();
    do_flush();
    fill({12'hA00, 8'd0}, {12'hCA0, 8'd0});
    fill({12'hB00, 8'd0}, {12'hCB0, 8'd0});
    fill({12'hC00, 8'd0}, {12'hCC0, 8'd0});
    fill({12'hD00, 8'd0}, {12'hCD0, 8'd0});
    for (int d = 1; d <= 24; d++) fill({12'hA00, 8'(d)}, {12'hCA0, 8'(d)});
    look({12'hB00, 8'd0}, 1'b0, 20'h0, "R7 sole entry evicted");
    look({12'hA00, 8'd0}, 1'b0, 20'h0, "R6 wrap victim");
    look({12'hA00, 8'd24}, 1'b1, {12'hCA0, 8'd24}, "R7 latest fill");
    fill({12'hF00, 8'd5}, {12'hCF0, 8'd6});
    look({12'hF00, 8'd5}, 1'b1, {12'hCF0, 8'd6}, "R7 freed pair reused");
    look({12'hC00, 8'd0}, 1'b0, 20'h0, "R7 compressed alloc evicted next");
    look({12'hD00, 8'd0}, 1'b1, {12'hCD0, 8'd0}, "R7 untouched entry");
  endtask

  // R8: flush, and flush over a same-cycle fill
  task automatic t_flush();
    do_flush();
    fill(20'h33311, 20'h44422);
    fill(20'h66611, 20'h77722);
    do_flush();
    look(20'h33311, 1'b0, 20'h0, "R8 flushed compressed");
    fill_valid = 1'b1; fill_vpn = 20'h88811; fill_pfn = 20'h99922; flush = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
    look(20'h88811, 1'b0, 20'h0, "R8 fill dropped by flush");
  endtask

  // R9 same-cycle miss, R11 lookup not stalled
  task automatic t_same_cycle();
    do_flush();
    fill(20'h2A001, 20'h3B001);
    fill_valid = 1'b1; fill_vpn = 20'h2A002; fill_pfn = 20'h3B002;
    lk_valid = 1'b1; lk_vpn = 20'h2A002;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk(lk_hit == 1'b0, "R9 same-cycle miss", 32'(lk_hit), 0);
    look(20'h2A002, 1'b1, 20'h3B002, "R9 visible next cycle");
    fill_valid = 1'b1; fill_vpn = 20'h2A003; fill_pfn = 20'h3B003;
    lk_valid = 1'b1; lk_vpn = 20'h2A001;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk(lk_hit == 1'b1, "R11 lookup during fill hit", 32'(lk_hit), 1);
    chk(lk_pfn == 20'h3B001, "R11 lookup during fill pfn", 32'(lk_pfn), 32'h3B001);
  endtask

  // R10: duplicates dropped in both partitions
  task automatic t_dup();
    do_flush();
    fill(20'h5A010, 20'h6B010);
    fill(20'h5A010, 20'h6B0EE);
    look(20'h5A010, 1'b1, 20'h6B010, "R10 compressed dup dropped");
    for (int b = 1; b < 4; b++) fill({12'(12'h5A0 + b), 8'h00}, {12'(12'h6C0 + b), 8'h00});
    fill(20'h7E001, 20'h8F001);
    fill(20'h7E001, 20'h8F0FF);
    look(20'h7E001, 1'b1, 20'h8F001, "R10 uncompressed dup dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pack();
    t_base_limit();
    t_uncomp();
    t_release();
    t_flush();
    t_same_cycle();
    t_dup();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule